// File: doc/BRIEF.md
# Mapping Checkpoint Recovery Scanner

After power-up, a storage controller must find a usable copy of its logical-to-physical mapping table before it can serve reads. The controller keeps several copies of the table header in a circular group of checkpoint slots inside a reserved, high-reliability address window. This block scans that window and hands the base address of the newest header that is still intact to the table-rebuild logic that follows it.

The scan has two phases. In the first phase the block reads the sequence word of every slot and picks the slot with the highest sequence value. In the second phase it validates candidates, starting with that slot. A candidate passes only when its signature word matches and its stored CRC-16 equals a CRC computed over its header. When a candidate fails, the block steps to the previous slot in the ring and tests it. If every slot fails, the block reports a fatal condition and stops. It uses one memory-read port with at most one read in flight, and a start/busy/done handshake.

Top module: `ckpt_recovery_scan`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `busy`, `done`, `found`, `fatal` and `rd_req` are low.
- R2: A `start` pulse sampled while `busy` is low raises `busy` on the next cycle. At the end of the scan, `done` pulses for one cycle in the same cycle that `busy` falls. A `start` sampled while `busy` is high has no effect on the reads or on the result.
- R3: The slot at index k occupies addresses REGION_BASE+4k to REGION_BASE+4k+3. Offset 0 holds the signature, offset 1 the sequence number, offset 2 the table base address, and offset 3 the CRC in bits 15:0. No read leaves the window of NUM_SLOTS*4 words.
- R4: `rd_req` is a one-cycle pulse that carries `rd_addr`. No new request is made until `rd_valid` has returned the data for the previous one. The memory may answer after any latency from 1 to 4 cycles.
- R5: The first candidate is the slot with the largest unsigned sequence number. When two slots tie, the lower slot index wins.
- R6: A candidate is valid only when word 0 equals SIGNATURE and word 3 bits 15:0 equal the CRC-16 of words 0, 1 and 2. The CRC uses polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR, and each word is fed most significant bit first.
- R7: After an invalid candidate, the next candidate is the slot one index lower. Slot 0 steps back to slot NUM_SLOTS-1.
- R8: When a candidate is valid, the scan ends with `found`=1 and `fatal`=0. `sel_slot` gives that slot index, and `sel_base` and `sel_seq` give its words 2 and 1.
- R9: When NUM_SLOTS candidates have all failed, the scan ends with `fatal`=1 and `found`=0. A scan never makes more than NUM_SLOTS+4*NUM_SLOTS reads. A scan that accepts its j-th candidate (counting from 1) makes exactly NUM_SLOTS+4j reads.
- R10: `found`, `fatal`, `sel_slot`, `sel_base` and `sel_seq` keep their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted while idle) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A valid checkpoint was selected |
| fatal | output | 1 | No slot passed validation |
| sel_slot | output | $clog2(NUM_SLOTS) | Index of the selected slot |
| sel_base | output | DATA_W | Table base address from the selected slot |
| sel_seq | output | DATA_W | Sequence number of the selected slot |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data word |

## Verification
The assertions assume that the memory raises `rd_valid` exactly once for each request and never when no request is outstanding. They also assume that `start` is only meaningful while idle. The bench memory model answers each request once after a latency that cycles through 1, 2, 3 and 4 cycles. It never answers unprompted. Stimulus corrupts either the signature or a CRC-covered word and leaves the sequence words intact, so the newest slot is chosen as R5 describes. Each scenario also counts the requests, which checks both the walk-back order and the bound on reads.

// File: rtl/ckpt_scan_pkg.sv
package ckpt_scan_pkg;

  // Header layout inside one slot (word offsets).
  localparam int HDR_WORDS  = 4;
  localparam int WSEL_W     = 2;
  localparam logic [WSEL_W-1:0] OFF_SIG  = 2'd0;
  localparam logic [WSEL_W-1:0] OFF_SEQ  = 2'd1;
  localparam logic [WSEL_W-1:0] OFF_BASE = 2'd2;
  localparam logic [WSEL_W-1:0] OFF_CRC  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN_RD,
    ST_SCAN_WT,
    ST_PICK,
    ST_CHK_RD,
    ST_CHK_WT,
    ST_EVAL
  } scan_state_e;

endpackage

// File: rtl/ckpt_crc16_acc.sv
module ckpt_crc16_acc #(
  parameter int          DATA_W = 32,
  parameter logic [15:0] POLY   = 16'h1021,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              feed,
  input  logic [DATA_W-1:0] word,
  output logic [15:0]       crc
);

  logic [15:0] nxt;

  // Bit-serial update unrolled over one word, MSB first.
  always_comb begin
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
    nxt = c;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= INIT;
    else if (feed)    crc <= nxt;
  end

endmodule

// File: rtl/ckpt_newest_pick.sv
module ckpt_newest_pick #(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              upd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] seq,
  output logic [SLOT_W-1:0] best_slot
);

  logic              have;
  logic [DATA_W-1:0] best_seq;

  // Strictly-greater compare: on a tie the earlier (lower) slot stays.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have      <= 1'b0;
      best_seq  <= '0;
      best_slot <= '0;
    end else if (upd && (!have || seq > best_seq)) begin
      have      <= 1'b1;
      best_seq  <= seq;
      best_slot <= slot;
    end
  end

  // R5: the held sequence value never decreases between clears
  a_r5_monotonic: assert property (@(posedge clk) disable iff (rst)
    (!clear && have) |=> (best_seq >= $past(best_seq)));

endmodule

// File: rtl/ckpt_rd_port.sv
module ckpt_rd_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              data_vld,
  output logic [DATA_W-1:0] data
);

  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      pending  <= 1'b0;
      data_vld <= 1'b0;
      data     <= '0;
    end else begin
      rd_req   <= 1'b0;
      data_vld <= 1'b0;
      if (issue && !pending) begin
        rd_req  <= 1'b1;
        rd_addr <= addr;
        pending <= 1'b1;
      end else if (pending && rd_valid) begin
        pending  <= 1'b0;
        data_vld <= 1'b1;
        data     <= rd_data;
      end
    end
  end

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R4: a request never overlaps an earlier outstanding one
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !$past(pending));

endmodule

// File: rtl/ckpt_recovery_scan.sv
module ckpt_recovery_scan
  import ckpt_scan_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 16,
  parameter int          NUM_SLOTS   = 8,
  parameter int          REGION_BASE = 64,
  parameter logic [31:0] SIGNATURE   = 32'h4D43_4B50,
  localparam int         SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              fatal,
  output logic [SLOT_W-1:0] sel_slot,
  output logic [DATA_W-1:0] sel_base,
  output logic [DATA_W-1:0] sel_seq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);

  localparam int MAX_READS  = NUM_SLOTS * (HDR_WORDS + 1);
  localparam int REGION_END = REGION_BASE + NUM_SLOTS * HDR_WORDS;
  localparam int CNT_W      = $clog2(MAX_READS + 2);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  scan_state_e       st;
  logic [SLOT_W-1:0] scan_idx;
  logic [SLOT_W-1:0] cand;
  logic [SLOT_W-1:0] tries;
  logic [WSEL_W-1:0] word_idx;
  logic              sig_ok;
  logic              crc_ok;
  logic [DATA_W-1:0] hdr_seq;
  logic [DATA_W-1:0] hdr_base;

  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic              data_vld;
  logic [DATA_W-1:0] data;
  logic [15:0]       crc_q;
  logic [SLOT_W-1:0] best_slot;
  logic              accept;

  function automatic logic [ADDR_W-1:0] slot_addr(
    input logic [SLOT_W-1:0] idx, input logic [WSEL_W-1:0] off);
    return ADDR_W'(REGION_BASE) + (ADDR_W'(idx) << WSEL_W) + ADDR_W'(off);
  endfunction

  assign accept     = (st == ST_IDLE) && start;
  assign issue      = (st == ST_SCAN_RD) || (st == ST_CHK_RD);
  assign issue_addr = (st == ST_SCAN_RD) ? slot_addr(scan_idx, OFF_SEQ)
                                         : slot_addr(cand, word_idx);

  ckpt_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .addr     (issue_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .data_vld (data_vld),
    .data     (data)
  );

  ckpt_newest_pick #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .upd       ((st == ST_SCAN_WT) && data_vld),
    .slot      (scan_idx),
    .seq       (data),
    .best_slot (best_slot)
  );

  ckpt_crc16_acc #(.DATA_W(DATA_W)) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear ((st == ST_CHK_RD) && (word_idx == OFF_SIG)),
    .feed  ((st == ST_CHK_WT) && data_vld && (word_idx != OFF_CRC)),
    .word  (data),
    .crc   (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      found    <= 1'b0;
      fatal    <= 1'b0;
      sel_slot <= '0;
      sel_base <= '0;
      sel_seq  <= '0;
      scan_idx <= '0;
      cand     <= '0;
      tries    <= '0;
      word_idx <= '0;
      sig_ok   <= 1'b0;
      crc_ok   <= 1'b0;
      hdr_seq  <= '0;
      hdr_base <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          busy     <= 1'b1;
          found    <= 1'b0;
          fatal    <= 1'b0;
          scan_idx <= '0;
          st       <= ST_SCAN_RD;
        end
        ST_SCAN_RD: st <= ST_SCAN_WT;
        ST_SCAN_WT: if (data_vld) begin
          if (scan_idx == LAST_SLOT) st <= ST_PICK;
          else begin
            scan_idx <= scan_idx + 1'b1;
            st       <= ST_SCAN_RD;
          end
        end
        ST_PICK: begin
          cand     <= best_slot;
          tries    <= '0;
          word_idx <= OFF_SIG;
          st       <= ST_CHK_RD;
        end
        ST_CHK_RD: st <= ST_CHK_WT;
        ST_CHK_WT: if (data_vld) begin
          unique case (word_idx)
            OFF_SIG:  sig_ok   <= (data == DATA_W'(SIGNATURE));
            OFF_SEQ:  hdr_seq  <= data;
            OFF_BASE: hdr_base <= data;
            default:  crc_ok   <= (data[15:0] == crc_q);
          endcase
          if (word_idx == OFF_CRC) st <= ST_EVAL;
          else begin
            word_idx <= word_idx + 1'b1;
            st       <= ST_CHK_RD;
          end
        end
        ST_EVAL: begin
          if (sig_ok && crc_ok) begin
            found    <= 1'b1;
            sel_slot <= cand;
            sel_base <= hdr_base;
            sel_seq  <= hdr_seq;
            done     <= 1'b1;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end else if (tries == LAST_SLOT) begin
            fatal <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            st    <= ST_IDLE;
          end else begin
            cand     <= (cand == '0) ? LAST_SLOT : cand - 1'b1;
            tries    <= tries + 1'b1;
            word_idx <= OFF_SIG;
            st       <= ST_CHK_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Read counter used only by the bound check below.
  logic [CNT_W-1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst || accept) rd_cnt <= '0;
    else if (rd_req)   rd_cnt <= rd_cnt + 1'b1;
  end

  // R9: a scan can never exceed its read budget
  a_r9_read_bound: assert property (@(posedge clk) disable iff (rst)
    int'(rd_cnt) <= MAX_READS);

  // R9/R8: a finished scan reports exactly one outcome
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (found != fatal));

  // R2: done coincides with the idle state
  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: start while idle raises busy next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R3: reads stay inside the reserved window
  a_r3_in_window: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (int'(rd_addr) >= REGION_BASE && int'(rd_addr) < REGION_END));

  // R10: results hold while idle without a new start
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(found) && $stable(fatal) && $stable(sel_slot)
                           && $stable(sel_base)));

endmodule

// File: tb/ckpt_recovery_scan_bench.sv
module ckpt_recovery_scan_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          DATA_W     = 32;
  localparam int          ADDR_W     = 16;
  localparam int          NSLOT      = 8;
  localparam int          RBASE      = 64;
  localparam logic [31:0] SIG        = 32'h4D43_4B50;
  localparam int          SW         = $clog2(NSLOT);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy, done, found, fatal;
  logic [SW-1:0]     sel_slot;
  logic [DATA_W-1:0] sel_base, sel_seq;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ckpt_recovery_scan #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NSLOT),
    .REGION_BASE(RBASE), .SIGNATURE(SIG)
  ) u_ckpt_recovery_scan (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .found(found), .fatal(fatal), .sel_slot(sel_slot), .sel_base(sel_base),
    .sel_seq(sel_seq), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Memory image of the reserved window and a latency-cycling responder.
  logic [31:0] mem [0:NSLOT*4-1];
  logic        m_pend = 1'b0;
  int          m_cnt = 0;
  int          m_lat = 1;
  int          m_idx = 0;
  int          n_reads = 0;
  int          n_overlap = 0;
  int          n_oob = 0;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      if (m_pend) n_overlap <= n_overlap + 1;
      if (int'(rd_addr) < RBASE || int'(rd_addr) >= RBASE + NSLOT * 4)
        n_oob <= n_oob + 1;
      n_reads <= n_reads + 1;
      m_pend  <= 1'b1;
      m_cnt   <= m_lat;
      m_idx   <= (int'(rd_addr) - RBASE) & (NSLOT * 4 - 1);
      m_lat   <= (m_lat == 4) ? 1 : m_lat + 1;
    end else if (m_pend) begin
      if (m_cnt == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[m_idx];
        m_pend   <= 1'b0;
      end else m_cnt <= m_cnt - 1;
    end
  end

  function automatic logic [15:0] ref_crc(input logic [31:0] a, b, c);
    logic [95:0] s;
    logic [15:0] r;
    logic        fb;
    s = {a, b, c};
    r = 16'hFFFF;
    for (int i = 95; i >= 0; i--) begin
      fb = r[15] ^ s[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] base_of(input int k);
    return 32'h1000_0000 + 32'(k) * 32'h100;
  endfunction

  task automatic write_slot(input int k, input logic [31:0] seq);
    mem[k*4+0] = SIG;
    mem[k*4+1] = seq;
    mem[k*4+2] = base_of(k);
    mem[k*4+3] = {16'h0000, ref_crc(SIG, seq, base_of(k))};
  endtask

  // Ring image in which slot `newest` holds the largest sequence value.
  task automatic load_ring(input int newest);
    for (int k = 0; k < NSLOT; k++)
      write_slot(k, 32'(100 + ((k - newest - 1 + 2 * NSLOT) % NSLOT)));
  endtask

  task automatic corrupt(input int k, input bit use_sig);
    if (use_sig) mem[k*4+0] = mem[k*4+0] ^ 32'h0000_0100;
    else         mem[k*4+2] = mem[k*4+2] ^ 32'h0004_0000;
  endtask

  task automatic run_scan(input string tag, input bit exp_found, input int exp_slot,
                          input int exp_reads, input bit extra_start);
    int r0;
    int waited;
    @(negedge clk);
    r0 = n_reads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy after start"}, 32'(busy), 32'd1);
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " R2 done seen"}, 32'(done), 32'd1);
    check({tag, " R2 busy low at done"}, 32'(busy), 32'd0);
    check({tag, " R8 found"}, 32'(found), 32'(exp_found));
    check({tag, " R9 fatal"}, 32'(fatal), 32'(!exp_found));
    if (exp_found) begin
      check({tag, " R7 slot"}, 32'(sel_slot), 32'(exp_slot));
      check({tag, " R8 base"}, sel_base, base_of(exp_slot));
      check({tag, " R8 seq"}, sel_seq, mem[exp_slot*4+1]);
    end
    check({tag, " R9 read count"}, 32'(n_reads - r0), 32'(exp_reads));
    @(negedge clk);
    check({tag, " R2 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R2 no restart"}, 32'(busy), 32'd0);
    check({tag, " R10 found held"}, 32'(found), 32'(exp_found));
    if (exp_found) check({tag, " R10 slot held"}, 32'(sel_slot), 32'(exp_slot));
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 found", 32'(found), 32'd0);
    check("R1 fatal", 32'(fatal), 32'd0);
    check("R1 rd_req", 32'(rd_req), 32'd0);
  endtask

  task automatic t_clean;        // R5 newest chosen, R6 passes
    load_ring(5);
    run_scan("clean", 1'b1, 5, NSLOT + 4, 1'b0);
  endtask

  task automatic t_one_bad;      // R6 signature mismatch, R7 step back
    load_ring(5);
    corrupt(5, 1'b1);
    run_scan("one", 1'b1, 4, NSLOT + 8, 1'b0);
  endtask

  task automatic t_three_bad;    // R6 CRC mismatch, R7
    load_ring(5);
    corrupt(5, 1'b0); corrupt(4, 1'b1); corrupt(3, 1'b0);
    run_scan("three", 1'b1, 2, NSLOT + 16, 1'b0);
  endtask

  task automatic t_wrap;         // R7 slot 0 steps back to last slot
    load_ring(2);
    corrupt(2, 1'b0); corrupt(1, 1'b1); corrupt(0, 1'b0);
    run_scan("wrap", 1'b1, 7, NSLOT + 16, 1'b0);
  endtask

  task automatic t_all_bad;      // R9 fatal after all slots
    load_ring(5);
    for (int k = 0; k < NSLOT; k++) corrupt(k, k[0]);
    run_scan("all", 1'b0, 0, NSLOT * 5, 1'b0);
    check("all R10 fatal held", 32'(fatal), 32'd1);
  endtask

  task automatic t_tie;          // R5 tie goes to lower index
    load_ring(5);
    write_slot(2, 32'd500);
    write_slot(6, 32'd500);
    run_scan("tie", 1'b1, 2, NSLOT + 4, 1'b0);
  endtask

  task automatic t_busy_start;   // R2 start while busy ignored
    load_ring(5);
    corrupt(5, 1'b1);
    run_scan("busystart", 1'b1, 4, NSLOT + 8, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_one_bad();
    t_three_bad();
    t_wrap();
    t_all_bad();
    t_tie();
    t_busy_start();
    check("R4 no overlapping request", 32'(n_overlap), 32'd0);
    check("R3 no read outside window", 32'(n_oob), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule